// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external static RAM that has no clock of its own. The RAM holds 256K words of 16 bits behind one shared data bus split into two byte lanes. It is controlled by active-low strobes: device select, write strobe, output drive enable and one enable per byte lane. The host hands over one word access at a time through a valid/ready handshake. Each request carries an 18-bit word address, 16 bits of write data, a 2-bit lane mask and a write flag. Reads come back as a single-cycle response pulse with the data.

The RAM's limits are given in picoseconds as parameters, together with the clock period. Each limit becomes a whole number of clock cycles, rounded up, and never fewer than one. The controller plays each access out as a fixed strobe sequence. It keeps output drive off for the whole of every write, so the shorter write pulse limit applies. It drives a data lane only while the write strobe is low and that lane is selected. After a read, it waits one extra idle cycle before it drives the bus again, so the RAM has time to release the pins.

With the default 8 ns clock, a write holds the strobes for one cycle and then takes one recovery cycle. A read holds the strobes for two cycles. Its response appears in the cycle after the read ends.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `req_ready` is 1, `rsp_valid` is 0, `ram_sel_n`, `ram_wstb_n`, `ram_drv_n` and both bits of `ram_lane_n` are 1, and `ram_dq_oe` is 0.
- R2: A request is taken only in a cycle where both `req_valid` and `req_ready` are 1. `req_ready` is 0 from the next cycle until the access has finished. Each accepted request causes exactly one low period of `ram_sel_n`.
- R3: Mask bit 0 selects data bits 7:0 and drives `ram_lane_n[0]` low during the access. Mask bit 1 selects bits 15:8 and drives `ram_lane_n[1]` low. A write changes only the selected lanes of the stored word.
- R4: During a write, `ram_wstb_n` is low only while `ram_sel_n` is low and `ram_drv_n` is high. It stays low for WP cycles, the largest rounded cycle count of write pulse (7 ns), select-to-end (7 ns), address-to-end (7 ns) and data setup (5 ns). This is 1 cycle at 8 ns.
- R5: `ram_dq_oe[i]` is 1 only while `ram_wstb_n` is low and `ram_lane_n[i]` is low. During every write cycle, `ram_dq_oe` equals the inverted `ram_lane_n`.
- R6: During a read, `ram_sel_n` and `ram_drv_n` are low and `ram_wstb_n` is high for RD cycles, the largest rounded count of address access, select access and read cycle time (10 ns each). This is 2 cycles at 8 ns. `ram_addr` holds the request address throughout.
- R7: The data on `ram_dq_in` is captured at the edge that ends the last read cycle. `rsp_valid` is 1 for exactly the following cycle, and `rsp_rdata` has the lanes outside the mask forced to 0.
- R8: After a read, at least two cycles with `ram_drv_n` high pass before any `ram_dq_oe` bit is 1. One of these is a dedicated turnaround cycle that the controller inserts before a write that follows a read.
- R9: After a write pulse, all strobes stay high for REC cycles. REC is the write cycle time rounded up, minus WP, with a minimum of 1, which is 1 cycle at 8 ns. `req_ready` therefore stays low for WP+REC cycles after a write is accepted, plus one if the write follows a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host presents a request |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| ram_addr | output | 18 | Address to the RAM |
| ram_dq_out | output | 16 | Data toward the RAM |
| ram_dq_oe | output | 2 | Per-lane drive enable for the shared bus |
| ram_dq_in | input | 16 | Data read from the shared bus |
| ram_sel_n | output | 1 | Active-low device select |
| ram_wstb_n | output | 1 | Active-low write strobe |
| ram_drv_n | output | 1 | Active-low RAM output drive enable |
| ram_lane_n | output | 2 | Active-low byte lane enables |

## Verification
A wrong state code or miscounted cycle timer shows up within a single access as a strobe low period of the wrong length. It also shows as a `req_ready` return on the wrong cycle. A lost turnaround appears on the very next write after a read, because the controller drives the bus one cycle after `ram_drv_n` rises. A broken lane decode or capture is visible in the first partial-mask access. It shows as a mismatch between `ram_dq_oe` and `ram_lane_n`, or as stray bits in `rsp_rdata` one cycle after the read.

// File: rtl/asram_ctrl_pkg.sv
package asram_ctrl_pkg;

    localparam int ADDR_W = 18;
    localparam int DATA_W = 16;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_WR,
        ST_WREC,
        ST_RD
    } ctl_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  mask;
    } host_req_t;

    // Round a limit up to whole clock cycles, never below one.
    function automatic int ps_to_cycles(input int limit_ps, input int clk_ps);
        int c;
        c = (limit_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R4/R6 strobe lengths rest on the timer stepping down by one per cycle
    assert_timer_step_R6: assert property (@(posedge clk) disable iff (rst)
        (!load && !expired) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_ctrl_pkg::*;
#(
    parameter int CNT_W  = 2,
    parameter int WP_LD  = 0,
    parameter int RD_LD  = 1,
    parameter int REC_LD = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             expired,
    output ctl_state_e       state,
    output logic             ready,
    output logic             accept,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             capture
);
    ctl_state_e nxt;
    logic       rd_last;

    always_comb begin
        nxt      = state;
        accept   = 1'b0;
        load     = 1'b0;
        load_val = '0;
        capture  = 1'b0;
        unique case (state)
            ST_IDLE: if (req_valid) begin
                accept = 1'b1;
                load   = 1'b1;
                if (!req_write) begin
                    nxt      = ST_RD;
                    load_val = CNT_W'(RD_LD);
                end else if (rd_last) begin
                    nxt = ST_TURN;
                end else begin
                    nxt      = ST_WR;
                    load_val = CNT_W'(WP_LD);
                end
            end
            ST_TURN: begin
                nxt      = ST_WR;
                load     = 1'b1;
                load_val = CNT_W'(WP_LD);
            end
            ST_WR: if (expired) begin
                nxt      = ST_WREC;
                load     = 1'b1;
                load_val = CNT_W'(REC_LD);
            end
            ST_WREC: if (expired) nxt = ST_IDLE;
            ST_RD: if (expired) begin
                nxt     = ST_IDLE;
                capture = 1'b1;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            rd_last <= 1'b0;
        end else begin
            state <= nxt;
            if (capture)
                rd_last <= 1'b1;
            else if (accept && req_write)
                rd_last <= 1'b0;
        end
    end

    assign ready = (state == ST_IDLE);

    assert_capture_single_R7: assert property (@(posedge clk) disable iff (rst)
        capture |=> !capture);

    assert_turn_leads_write_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TURN) |=> (state == ST_WR));

endmodule

// File: rtl/asram_lane.sv
module asram_lane
    import asram_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_act,
    input  logic              wr_act,
    input  logic              sel,
    input  logic              capture,
    input  logic [LANE_W-1:0] wbyte,
    input  logic [LANE_W-1:0] bus_in,
    output logic              lane_n,
    output logic              drive,
    output logic [LANE_W-1:0] bus_out,
    output logic [LANE_W-1:0] rbyte
);
    assign lane_n  = !(acc_act && sel);
    assign drive   = wr_act && sel;
    assign bus_out = wbyte;

    always_ff @(posedge clk) begin
        if (rst)
            rbyte <= '0;
        else if (capture)
            rbyte <= sel ? bus_in : '0;
    end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_ctrl_pkg::*;
#(
    parameter int CLK_PS    = 8000,
    parameter int T_WP_PS   = 7000,
    parameter int T_CW_PS   = 7000,
    parameter int T_AW_PS   = 7000,
    parameter int T_DW_PS   = 5000,
    parameter int T_WC_PS   = 10000,
    parameter int T_AA_PS   = 10000,
    parameter int T_ACS_PS  = 10000,
    parameter int T_RC_PS   = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic [LANES-1:0]  ram_dq_oe,
    input  logic [DATA_W-1:0] ram_dq_in,
    output logic              ram_sel_n,
    output logic              ram_wstb_n,
    output logic              ram_drv_n,
    output logic [LANES-1:0]  ram_lane_n
);
    localparam int WP_CYC  = imax(imax(ps_to_cycles(T_WP_PS, CLK_PS), ps_to_cycles(T_CW_PS, CLK_PS)),
                                  imax(ps_to_cycles(T_AW_PS, CLK_PS), ps_to_cycles(T_DW_PS, CLK_PS)));
    localparam int RD_CYC  = imax(imax(ps_to_cycles(T_AA_PS, CLK_PS), ps_to_cycles(T_ACS_PS, CLK_PS)),
                                  ps_to_cycles(T_RC_PS, CLK_PS));
    localparam int REC_CYC = imax(1, ps_to_cycles(T_WC_PS, CLK_PS) - WP_CYC);
    localparam int MAX_CYC = imax(imax(WP_CYC, RD_CYC), REC_CYC);
    localparam int CNT_W   = ($clog2(MAX_CYC) < 1) ? 1 : $clog2(MAX_CYC);

    ctl_state_e       state;
    logic             accept, load, expired, capture;
    logic [CNT_W-1:0] load_val;
    host_req_t        req_q;
    logic             acc_act, wr_act;

    asram_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    asram_seq #(
        .CNT_W  (CNT_W),
        .WP_LD  (WP_CYC - 1),
        .RD_LD  (RD_CYC - 1),
        .REC_LD (REC_CYC - 1)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .expired   (expired),
        .state     (state),
        .ready     (req_ready),
        .accept    (accept),
        .load      (load),
        .load_val  (load_val),
        .capture   (capture)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q     <= '0;
            rsp_valid <= 1'b0;
        end else begin
            if (accept)
                req_q <= '{addr: req_addr, wdata: req_wdata, mask: req_mask};
            rsp_valid <= capture;
        end
    end

    assign acc_act    = (state == ST_WR) || (state == ST_RD);
    assign wr_act     = (state == ST_WR);
    assign ram_sel_n  = !acc_act;
    assign ram_wstb_n = !wr_act;
    assign ram_drv_n  = !(state == ST_RD);
    assign ram_addr   = req_q.addr;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        asram_lane u_lane (
            .clk     (clk),
            .rst     (rst),
            .acc_act (acc_act),
            .wr_act  (wr_act),
            .sel     (req_q.mask[g]),
            .capture (capture),
            .wbyte   (req_q.wdata[g*LANE_W +: LANE_W]),
            .bus_in  (ram_dq_in[g*LANE_W +: LANE_W]),
            .lane_n  (ram_lane_n[g]),
            .drive   (ram_dq_oe[g]),
            .bus_out (ram_dq_out[g*LANE_W +: LANE_W]),
            .rbyte   (rsp_rdata[g*LANE_W +: LANE_W])
        );
    end

    assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_wstb_framed_R4: assert property (@(posedge clk) disable iff (rst)
        !ram_wstb_n |-> (!ram_sel_n && ram_drv_n));

    assert_drive_in_write_R5: assert property (@(posedge clk) disable iff (rst)
        (ram_dq_oe != '0) |-> !ram_wstb_n);

    assert_read_addr_held_R6: assert property (@(posedge clk) disable iff (rst)
        (!ram_drv_n && $past(!ram_drv_n)) |-> $stable(ram_addr));

    assert_rsp_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_bus_turnaround_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(!ram_drv_n) || $past(!ram_drv_n, 2)) |-> (ram_dq_oe == '0));

endmodule

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;

    localparam int CLK_PS = 8000;

    function automatic int up_div(input int a, input int b);
        int c;
        c = (a + b - 1) / b;
        return (c < 1) ? 1 : c;
    endfunction

    // Expected cycle counts worked out from the requirements
    localparam int WP_E  = 1;  // ceil(7/8)=1, ceil(5/8)=1
    localparam int RD_E  = 2;  // ceil(10/8)=2
    localparam int REC_E = 1;  // max(1, 2-1)

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_write;
    logic [17:0] req_addr;
    logic [15:0] req_wdata;
    logic [1:0]  req_mask;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [17:0] ram_addr;
    logic [15:0] ram_dq_out, ram_dq_in;
    logic [1:0]  ram_dq_oe, ram_lane_n;
    logic        ram_sel_n, ram_wstb_n, ram_drv_n;

    always #4ns clk = ~clk;

    asram_ctrl u_dut (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_mask   (req_mask),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .ram_addr   (ram_addr),
        .ram_dq_out (ram_dq_out),
        .ram_dq_oe  (ram_dq_oe),
        .ram_dq_in  (ram_dq_in),
        .ram_sel_n  (ram_sel_n),
        .ram_wstb_n (ram_wstb_n),
        .ram_drv_n  (ram_drv_n),
        .ram_lane_n (ram_lane_n)
    );

    // RAM model, indexed by the low 10 address bits
    logic [15:0] mem    [0:1023];
    logic [15:0] shadow [0:1023];

    always @(posedge clk) begin
        if (!ram_sel_n && !ram_wstb_n) begin
            if (ram_dq_oe[0] && !ram_lane_n[0]) mem[ram_addr[9:0]][7:0]  <= ram_dq_out[7:0];
            if (ram_dq_oe[1] && !ram_lane_n[1]) mem[ram_addr[9:0]][15:8] <= ram_dq_out[15:8];
        end
    end

    always_comb begin
        ram_dq_in = 16'hEEEE;
        if (!ram_sel_n && !ram_drv_n && ram_wstb_n) begin
            if (!ram_lane_n[0]) ram_dq_in[7:0]  = mem[ram_addr[9:0]][7:0];
            if (!ram_lane_n[1]) ram_dq_in[15:8] = mem[ram_addr[9:0]][15:8];
        end
    end

    int n_tot = 0;
    int n_bad = 0;
    logic [15:0] exp_q [$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tot++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: strobe shapes and scoreboard for read responses
    int          we_run = 0, rd_run = 0, drv_hi = 0, sel_falls = 0;
    bit          after_rd = 1'b0, prev_sel = 1'b1;
    logic [17:0] rd_addr;

    always @(negedge clk) begin
        if (!rst) begin
            if (!ram_wstb_n) begin
                if (we_run == 0) begin
                    if (after_rd) begin
                        chk(drv_hi >= 2, "R8 turnaround cycles", drv_hi, 2);
                        after_rd = 1'b0;
                    end
                    chk(!ram_sel_n && ram_drv_n, "R4 select low, drive high", {ram_sel_n, ram_drv_n}, 2'b01);
                end
                chk(ram_dq_oe == ~ram_lane_n, "R5 drive per lane", ram_dq_oe, ~ram_lane_n);
                we_run++;
            end else begin
                if (ram_dq_oe != 2'b00) chk(1'b0, "R5 drive without strobe", ram_dq_oe, 0);
                if (we_run != 0) chk(we_run == WP_E, "R4 write pulse length", we_run, WP_E);
                we_run = 0;
            end
            if (!ram_drv_n) begin
                if (rd_run == 0) rd_addr = ram_addr;
                else chk(ram_addr == rd_addr, "R6 address held", ram_addr, rd_addr);
                rd_run++;
                drv_hi   = 0;
                after_rd = 1'b1;
            end else begin
                if (rd_run != 0) chk(rd_run == RD_E, "R6 read length", rd_run, RD_E);
                rd_run = 0;
                drv_hi++;
            end
            if (prev_sel && !ram_sel_n) sel_falls++;
            prev_sel = ram_sel_n;
            if (rsp_valid) begin
                if (exp_q.size() == 0) chk(1'b0, "R7 unexpected response", rsp_rdata, 0);
                else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk(rsp_rdata == e, "R7 read data", rsp_rdata, e);
                end
            end
        end
    end

    // Driver
    int ops = 0;
    bit last_rd = 1'b0;

    task automatic do_op(input bit w, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
        int  lat;
        int  exp_lat;
        bit  lchk;
        logic [15:0] mk;
        mk = {{8{m[1]}}, {8{m[0]}}};
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
        while (!req_ready) @(negedge clk);
        if (w) shadow[a[9:0]] = (shadow[a[9:0]] & ~mk) | (d & mk);
        else exp_q.push_back(shadow[a[9:0]] & mk);
        exp_lat = w ? ((last_rd ? 1 : 0) + WP_E + REC_E) : RD_E;
        @(negedge clk);
        req_valid = 1'b0;
        ops++;
        lat  = 0;
        lchk = 1'b0;
        while (!req_ready) begin
            lat++;
            if (!ram_sel_n && !lchk) begin
                chk(ram_lane_n == ~m, "R3 lane strobes follow mask", ram_lane_n, ~m);
                chk(ram_addr == a, "R3 address of access", ram_addr, a);
                lchk = 1'b1;
            end
            @(negedge clk);
        end
        chk(lat == exp_lat, w ? "R9 write busy cycles" : "R2 read busy cycles", lat, exp_lat);
        last_rd = !w;
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            mem[i]    = 16'h0000;
            shadow[i] = 16'h0000;
        end
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0; req_mask = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
        chk({ram_sel_n, ram_wstb_n, ram_drv_n, ram_lane_n} == 5'b11111, "R1 strobes idle",
            {ram_sel_n, ram_wstb_n, ram_drv_n, ram_lane_n}, 5'b11111);
        chk(ram_dq_oe == 2'b00, "R1 bus released", ram_dq_oe, 0);

        do_op(1'b1, 18'h00010, 16'h1234, 2'b11);
        do_op(1'b0, 18'h00010, 16'h0000, 2'b11);
        do_op(1'b1, 18'h00010, 16'hABCD, 2'b01);   // R3 lower lane only, follows read
        do_op(1'b0, 18'h00010, 16'h0000, 2'b11);
        do_op(1'b1, 18'h3FF21, 16'h5678, 2'b10);   // R3 upper lane only
        do_op(1'b0, 18'h3FF21, 16'h0000, 2'b10);
        do_op(1'b0, 18'h00010, 16'h0000, 2'b01);   // R7 upper lane must read zero
        do_op(1'b0, 18'h3FF21, 16'h0000, 2'b11);
        for (int i = 0; i < 8; i++)
            do_op(1'b1, 18'h20000 + 18'(i * 37), 16'(16'h1111 * i) ^ 16'h5A3C, 2'(i % 3 + 1));
        for (int i = 0; i < 8; i++) begin
            do_op(1'b0, 18'h20000 + 18'(i * 37), 16'h0000, 2'((i + 1) % 3 + 1));
            do_op(1'b1, 18'h20000 + 18'(i * 37), 16'hC0DE, 2'b01);
        end
        repeat (6) @(negedge clk);
        chk(exp_q.size() == 0, "R7 every read answered", exp_q.size(), 0);
        chk(sel_falls == ops, "R2 one access per request", sel_falls, ops);
        chk(up_div(10000, CLK_PS) == RD_E, "R6 bench cycle count", up_div(10000, CLK_PS), RD_E);
        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

    initial begin
        #1600us;
        n_tot++;
        n_bad++;
        $display("FAIL watchdog R2 actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

endmodule